// File: doc/BRIEF.md
# Relocating Row Configuration Store

This block holds the configuration rows of a row-based reconfigurable array. Storage is a set of `ROWS` rows, each `ROW_W` bits wide, and a row is the smallest unit that can be handed to a configuration. Every configuration is compiled as if it started at row 0. When it is loaded, an offset register chosen at run time is added to each row number, so the same bitstream can be placed anywhere that has enough free rows.

A second command moves already resident rows from one place to another. Each row is read into a row-wide holding buffer and then written back in full at its new position. A read offset and a write offset feed a single row-address adder through a two-way selector. A placement manager outside the block uses moves to slide resident configurations toward row 0, so that scattered free rows merge into one run. The order in which rows are copied is picked from the direction of the move, so a move whose source and destination overlap still gives the right result. Choosing where to place a configuration and which one to evict is left to the manager.

A combinational inspect port returns any stored row. This lets the surrounding fabric, and a test, observe the array contents.

Top module: `cfgmem_reloc`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `err` are all 0.
- R2: An accepted load writes stream row i (i from 0) to physical row `ld_off + i`. One row is written on each clock edge that finds `busy` and `ld_valid` both high. Edges with `ld_valid` low write nothing and do not advance the stream.
- R3: When the last row of a load is written, `busy` drops and `done` is 1 for exactly one cycle, in the cycle that follows that write.
- R4: An accepted move of `mv_cnt` rows copies the old contents of row `mv_src + i` to row `mv_dst + i` for every i below `mv_cnt`. `busy` stays high for exactly 2*`mv_cnt` cycles, one read cycle and one write cycle per row, and `done` pulses once in the cycle after the final write.
- R5: A move with `mv_dst < mv_src` copies rows in increasing order, so overlapping source and destination ranges give the same result as a copy through a separate buffer. A move with `mv_dst == mv_src` leaves the array unchanged.
- R6: A move with `mv_dst > mv_src` copies rows in decreasing order, so overlapping ranges give the same result as a copy through a separate buffer.
- R7: A load with `ld_off + ld_cnt > ROWS`, or a move with `mv_src + mv_cnt > ROWS` or `mv_dst + mv_cnt > ROWS`, is rejected. In the cycle after the command, `err` and `done` are both 1 for one cycle, `busy` stays 0, and no row changes. A range that ends exactly at `ROWS` is accepted.
- R8: A command with a count of 0 that passes the range check gives one `done` pulse in the next cycle with `err` 0 and `busy` 0, and changes no row.
- R9: Commands are sampled only while `busy` is 0. If `ld_start` and `mv_start` are both high, the load is taken and the move is dropped. A start raised while `busy` is 1 is ignored.
- R10: `peek_data` always shows the current contents of row `peek_addr`.
- R11: Rows outside the destination range of a command are never modified by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_start | input | 1 | Start a load command |
| ld_off | input | AW | Placement offset for the load |
| ld_cnt | input | CW | Number of rows to load |
| ld_valid | input | 1 | Stream row present on `ld_data` |
| ld_data | input | ROW_W | Stream row data |
| mv_start | input | 1 | Start a move command |
| mv_src | input | AW | First source row of the move |
| mv_dst | input | AW | First destination row of the move |
| mv_cnt | input | CW | Number of rows to move |
| peek_addr | input | AW | Row to inspect |
| peek_data | output | ROW_W | Contents of row `peek_addr` |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse when a command finishes or is rejected |
| err | output | 1 | One-cycle pulse, together with `done`, on a rejected command |

## Verification
A wrong copy direction or a stale buffer shows up on `peek_data` as soon as the move ends. An overlapping move then shows repeated rows where shifted rows were expected. An off-by-one in the offset adder or the row index shifts or clips whole rows, and corrupts a neighbour that should have stayed untouched. A miscounted end index shows up as a `busy` window that is longer or shorter than 2 cycles per moved row, or as too few load rows consumed, in the cycle the command finishes. A faulty range check is visible one cycle after the command, through `err` or through rows that changed even though the command was rejected.

// File: rtl/cfgmem_pkg.sv
package cfgmem_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_MVRD,
        ST_MVWR
    } seq_state_e;

    // array control word driven by the sequencer
    typedef struct packed {
        logic we;        // write the addressed row
        logic from_buf;  // write source is the holding buffer
        logic cap;       // capture the addressed row into the buffer
    } arr_ctl_t;

    // true when rows [base, base+cnt) lie inside the array
    function automatic logic span_fits(input int unsigned base,
                                       input int unsigned cnt,
                                       input int unsigned rows);
        return (base + cnt) <= rows;
    endfunction

endpackage

// File: rtl/cfgmem_rowaddr.sv
module cfgmem_rowaddr #(
    parameter int AW = 4
) (
    input  logic [AW-1:0] rd_off,
    input  logic [AW-1:0] wr_off,
    input  logic          use_wr,
    input  logic [AW-1:0] idx,
    output logic [AW-1:0] phys
);
    logic [AW-1:0] base;

    // 2:1 offset select feeding one row-address adder
    always_comb begin
        base = use_wr ? wr_off : rd_off;
        phys = base + idx;
    end
endmodule

// File: rtl/cfgmem_array.sv
module cfgmem_array
    import cfgmem_pkg::*;
#(
    parameter int ROWS  = 16,
    parameter int ROW_W = 32,
    parameter int AW    = $clog2(ROWS)
) (
    input  logic             clk,
    input  arr_ctl_t         ctl,
    input  logic [AW-1:0]    addr,
    input  logic [ROW_W-1:0] ld_data,
    input  logic [AW-1:0]    peek_addr,
    output logic [ROW_W-1:0] peek_data
);
    logic [ROW_W-1:0] mem [ROWS];
    logic [ROW_W-1:0] rowbuf;

    // full-width row write, no column selection
    always_ff @(posedge clk) begin
        if (ctl.cap) begin
            rowbuf <= mem[addr];
        end
        if (ctl.we) begin
            mem[addr] <= ctl.from_buf ? rowbuf : ld_data;
        end
    end

    assign peek_data = mem[peek_addr];
endmodule

// File: rtl/cfgmem_seq.sv
module cfgmem_seq
    import cfgmem_pkg::*;
#(
    parameter int ROWS = 16,
    parameter int AW   = $clog2(ROWS),
    parameter int CW   = $clog2(ROWS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_start,
    input  logic [AW-1:0] ld_off,
    input  logic [CW-1:0] ld_cnt,
    input  logic          ld_valid,
    input  logic          mv_start,
    input  logic [AW-1:0] mv_src,
    input  logic [AW-1:0] mv_dst,
    input  logic [CW-1:0] mv_cnt,
    output logic [AW-1:0] rd_off,
    output logic [AW-1:0] wr_off,
    output logic          use_wr,
    output logic [AW-1:0] idx,
    output arr_ctl_t      ctl,
    output logic          busy,
    output logic          done,
    output logic          err
);
    seq_state_e    state;
    logic [AW-1:0] end_idx;
    logic          down;
    logic          ld_ok, mv_ok, mv_down;
    logic [AW-1:0] ld_last, mv_last;

    always_comb begin
        ld_ok   = span_fits(32'(ld_off), 32'(ld_cnt), ROWS);
        mv_ok   = span_fits(32'(mv_src), 32'(mv_cnt), ROWS) &&
                  span_fits(32'(mv_dst), 32'(mv_cnt), ROWS);
        mv_down = mv_dst > mv_src;
        ld_last = AW'(ld_cnt - CW'(1));
        mv_last = AW'(mv_cnt - CW'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            done    <= 1'b0;
            err     <= 1'b0;
            idx     <= '0;
            end_idx <= '0;
            rd_off  <= '0;
            wr_off  <= '0;
            down    <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (ld_start) begin
                        if (!ld_ok) begin
                            done <= 1'b1;
                            err  <= 1'b1;
                        end else if (ld_cnt == '0) begin
                            done <= 1'b1;
                        end else begin
                            wr_off  <= ld_off;
                            idx     <= '0;
                            end_idx <= ld_last;
                            down    <= 1'b0;
                            state   <= ST_LOAD;
                        end
                    end else if (mv_start) begin
                        if (!mv_ok) begin
                            done <= 1'b1;
                            err  <= 1'b1;
                        end else if (mv_cnt == '0) begin
                            done <= 1'b1;
                        end else begin
                            rd_off  <= mv_src;
                            wr_off  <= mv_dst;
                            down    <= mv_down;
                            // downward moves walk from the far end first
                            idx     <= mv_down ? mv_last : '0;
                            end_idx <= mv_down ? '0 : mv_last;
                            state   <= ST_MVRD;
                        end
                    end
                end
                ST_LOAD: begin
                    if (ld_valid) begin
                        if (idx == end_idx) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            idx <= idx + AW'(1);
                        end
                    end
                end
                ST_MVRD: state <= ST_MVWR;
                ST_MVWR: begin
                    if (idx == end_idx) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        idx   <= down ? idx - AW'(1) : idx + AW'(1);
                        state <= ST_MVRD;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy         = state != ST_IDLE;
        use_wr       = state != ST_MVRD;
        ctl.cap      = state == ST_MVRD;
        ctl.from_buf = state == ST_MVWR;
        ctl.we       = (state == ST_LOAD && ld_valid) || state == ST_MVWR;
    end
endmodule

// File: rtl/cfgmem_reloc.sv
module cfgmem_reloc
    import cfgmem_pkg::*;
#(
    parameter  int ROWS  = 16,
    parameter  int ROW_W = 32,
    localparam int AW    = $clog2(ROWS),
    localparam int CW    = $clog2(ROWS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_start,
    input  logic [AW-1:0]    ld_off,
    input  logic [CW-1:0]    ld_cnt,
    input  logic             ld_valid,
    input  logic [ROW_W-1:0] ld_data,
    input  logic             mv_start,
    input  logic [AW-1:0]    mv_src,
    input  logic [AW-1:0]    mv_dst,
    input  logic [CW-1:0]    mv_cnt,
    input  logic [AW-1:0]    peek_addr,
    output logic [ROW_W-1:0] peek_data,
    output logic             busy,
    output logic             done,
    output logic             err
);
    logic [AW-1:0] rd_off, wr_off, idx, phys;
    logic          use_wr;
    arr_ctl_t      ctl;

    cfgmem_seq #(.ROWS(ROWS), .AW(AW), .CW(CW)) u_seq (
        .clk(clk), .rst(rst),
        .ld_start(ld_start), .ld_off(ld_off), .ld_cnt(ld_cnt), .ld_valid(ld_valid),
        .mv_start(mv_start), .mv_src(mv_src), .mv_dst(mv_dst), .mv_cnt(mv_cnt),
        .rd_off(rd_off), .wr_off(wr_off), .use_wr(use_wr), .idx(idx), .ctl(ctl),
        .busy(busy), .done(done), .err(err)
    );

    cfgmem_rowaddr #(.AW(AW)) u_addr (
        .rd_off(rd_off), .wr_off(wr_off), .use_wr(use_wr), .idx(idx), .phys(phys)
    );

    cfgmem_array #(.ROWS(ROWS), .ROW_W(ROW_W), .AW(AW)) u_arr (
        .clk(clk), .ctl(ctl), .addr(phys), .ld_data(ld_data),
        .peek_addr(peek_addr), .peek_data(peek_data)
    );
endmodule

// File: rtl/cfgmem_chk.sv
module cfgmem_chk #(
    parameter  int ROWS  = 16,
    parameter  int ROW_W = 32,
    localparam int AW    = $clog2(ROWS),
    localparam int CW    = $clog2(ROWS + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             ld_start,
    input logic [AW-1:0]    ld_off,
    input logic [CW-1:0]    ld_cnt,
    input logic             ld_valid,
    input logic [ROW_W-1:0] ld_data,
    input logic             mv_start,
    input logic [AW-1:0]    mv_src,
    input logic [AW-1:0]    mv_dst,
    input logic [CW-1:0]    mv_cnt,
    input logic [AW-1:0]    peek_addr,
    input logic [ROW_W-1:0] peek_data,
    input logic             busy,
    input logic             done,
    input logic             err
);
    logic mv_in_range;
    assign mv_in_range = (32'(mv_src) + 32'(mv_cnt) <= ROWS) &&
                         (32'(mv_dst) + 32'(mv_cnt) <= ROWS);

    // R7
    err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> (done && !busy));

    // R7
    load_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && ld_start && (32'(ld_off) + 32'(ld_cnt) > ROWS)) |=> (err && !busy));

    // R4
    move_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !ld_start && mv_start && mv_cnt != '0 && mv_in_range) |=> (busy && !done));

    // R3
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R8
    zero_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && ld_start && ld_cnt == '0) |=> (done && !err && !busy));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!busy && !ld_start && !mv_start) && $stable(peek_addr)) |-> $stable(peek_data));
endmodule

bind cfgmem_reloc cfgmem_chk #(.ROWS(ROWS), .ROW_W(ROW_W)) u_chk (.*);

// File: tb/sim_cfgmem_reloc.sv
module sim_cfgmem_reloc;
    localparam int CLK_PERIOD = 10;
    localparam int ROWS  = 16;
    localparam int ROW_W = 32;
    localparam int AW    = $clog2(ROWS);
    localparam int CW    = $clog2(ROWS + 1);
    localparam int NVEC  = 13;

    // fields: [31:24] kind (0 load, 1 move), [23:16] off/src, [15:8] dst, [7:0] count
    localparam logic [31:0] VEC [NVEC] = '{
        {8'd0, 8'd0,  8'd0,  8'd16},
        {8'd0, 8'd6,  8'd0,  8'd5},
        {8'd0, 8'd12, 8'd0,  8'd4},
        {8'd0, 8'd13, 8'd0,  8'd4},
        {8'd1, 8'd6,  8'd4,  8'd5},
        {8'd1, 8'd0,  8'd2,  8'd4},
        {8'd1, 8'd12, 8'd9,  8'd4},
        {8'd1, 8'd10, 8'd14, 8'd3},
        {8'd1, 8'd5,  8'd5,  8'd3},
        {8'd0, 8'd3,  8'd0,  8'd0},
        {8'd1, 8'd15, 8'd0,  8'd1},
        {8'd1, 8'd0,  8'd15, 8'd1},
        {8'd1, 8'd14, 8'd0,  8'd3}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ld_start = 1'b0, ld_valid = 1'b0, mv_start = 1'b0;
    logic [AW-1:0]    ld_off = '0, mv_src = '0, mv_dst = '0, peek_addr = '0;
    logic [CW-1:0]    ld_cnt = '0, mv_cnt = '0;
    logic [ROW_W-1:0] ld_data = '0;
    logic [ROW_W-1:0] peek_data;
    logic             busy, done, err;

    logic [ROW_W-1:0] model [ROWS];
    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cfgmem_reloc #(.ROWS(ROWS), .ROW_W(ROW_W)) u0 (
        .clk(clk), .rst(rst),
        .ld_start(ld_start), .ld_off(ld_off), .ld_cnt(ld_cnt),
        .ld_valid(ld_valid), .ld_data(ld_data),
        .mv_start(mv_start), .mv_src(mv_src), .mv_dst(mv_dst), .mv_cnt(mv_cnt),
        .peek_addr(peek_addr), .peek_data(peek_data),
        .busy(busy), .done(done), .err(err)
    );

    function automatic logic [ROW_W-1:0] pat(input int tag, input int i);
        return ROW_W'(32'(tag) * 32'h0001_0001 + 32'(i) * 32'h0000_0110 + 32'h5A00_0000);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint got, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic cmp_array(input string req);
        int bad_row = -1;
        logic [ROW_W-1:0] bad_got = '0;
        for (int r = 0; r < ROWS; r++) begin
            peek_addr = AW'(r);
            #1;
            if (bad_row < 0 && peek_data !== model[r]) begin
                bad_row = r;
                bad_got = peek_data;
            end
        end
        if (bad_row < 0) check(1'b1, req, "array", 0, 0);
        else check(1'b0, req, $sformatf("row %0d", bad_row), longint'(bad_got),
                   longint'(model[bad_row]));
    endtask

    // kind 0 load, 1 move; gaps: drop ld_valid on some cycles; poke: start during busy;
    // both: raise ld_start and mv_start together
    task automatic do_cmd(input int kind, input int a, input int b, input int c,
                          input int tag, input bit gaps, input bit poke, input bit both);
        int busy_cnt = 0;
        int k = 0;
        int gap_cnt = 0;
        int exp_busy;
        bit exp_err;
        string req;
        logic [ROW_W-1:0] tmp [ROWS];
        exp_err = (a + c > ROWS) || (kind == 1 && b + c > ROWS);
        if (exp_err) req = "R7";
        else if (c == 0) req = "R8";
        else if (both || poke) req = "R9";
        else if (kind == 0) req = "R2";
        else if (b <= a) req = "R5";
        else req = "R6";

        @(negedge clk);
        if (kind == 0 || both) begin
            ld_start = 1'b1; ld_off = AW'(a); ld_cnt = CW'(c);
        end
        if (kind == 1 || both) begin
            mv_start = 1'b1; mv_src = AW'(a); mv_dst = AW'(b); mv_cnt = CW'(c);
            if (both) begin mv_src = AW'(0); mv_dst = AW'(1); mv_cnt = CW'(3); end
        end
        @(negedge clk);
        ld_start = 1'b0;
        mv_start = 1'b0;
        while (busy) begin
            busy_cnt++;
            if (poke && busy_cnt == 1) begin
                ld_start = 1'b1; ld_off = '0; ld_cnt = CW'(1);
                mv_start = 1'b1; mv_src = '0; mv_dst = AW'(1); mv_cnt = CW'(1);
            end else begin
                ld_start = 1'b0;
                mv_start = 1'b0;
            end
            if (kind == 0) begin
                if (gaps && (busy_cnt % 3) == 2) begin
                    ld_valid = 1'b0;
                    gap_cnt++;
                end else begin
                    ld_valid = 1'b1;
                    ld_data  = pat(tag, k);
                    k++;
                end
            end
            @(negedge clk);
            if (busy_cnt > 4 * ROWS + 8) break;
        end
        ld_valid = 1'b0;
        ld_start = 1'b0;
        mv_start = 1'b0;

        if (exp_err || c == 0) exp_busy = 0;
        else if (kind == 0) exp_busy = c + gap_cnt;
        else exp_busy = 2 * c;

        check(done === 1'b1, (kind == 0) ? "R3" : "R4", "done after command", done, 1);
        check(err === exp_err, "R7", "err flag", err, exp_err);
        check(busy_cnt == exp_busy, (kind == 0) ? "R3" : "R4", "busy cycles",
              busy_cnt, exp_busy);

        if (!exp_err) begin
            if (kind == 0) begin
                for (int i = 0; i < c; i++) model[a + i] = pat(tag, i);
            end else begin
                for (int r = 0; r < ROWS; r++) tmp[r] = model[r];
                for (int i = 0; i < c; i++) model[b + i] = tmp[a + i];
            end
        end
        // R10 / R11: inspect port must match the model on every row
        cmp_array(req);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(busy === 1'b0, "R1", "busy after reset", busy, 0);
        check(done === 1'b0, "R1", "done after reset", done, 0);
        check(err === 1'b0, "R1", "err after reset", err, 0);

        for (int v = 0; v < NVEC; v++) begin
            do_cmd(int'(VEC[v][31:24]), int'(VEC[v][23:16]), int'(VEC[v][15:8]),
                   int'(VEC[v][7:0]), v + 1, 1'b0, 1'b0, 1'b0);
        end

        // R2: load with stalled stream cycles
        do_cmd(0, 2, 0, 6, 40, 1'b1, 1'b0, 1'b0);
        // R9: simultaneous starts, the load wins
        do_cmd(0, 8, 0, 2, 41, 1'b0, 1'b0, 1'b1);
        // R9: starts raised while busy are ignored
        do_cmd(1, 3, 7, 4, 42, 1'b0, 1'b1, 1'b0);
        // R8: zero-count move
        do_cmd(1, 4, 9, 0, 43, 1'b0, 1'b0, 1'b0);
        // R6: full-span downward move of 15 rows
        do_cmd(1, 0, 1, 15, 44, 1'b0, 1'b0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule